// File: doc/BRIEF.md
# Multi-Channel Peripheral DMA Controller

The block moves data between peripherals and one port of a dual-port RAM. It uses a private transfer bus, so the CPU keeps running. Every peripheral request line has its own steering bit. The bit sends the request either to the CPU interrupt logic or to one DMA channel, never to both. A channel that is armed and receives a request stores it as pending. The pending channels are arbitrated each cycle. The winner drives exactly one byte or one 16-bit word across the bus in the following cycle.

Each channel is set up through static configuration inputs:
- a peripheral register address;
- two RAM buffer bases, buffer A and buffer B;
- a block length;
- a width bit selecting byte or word transfers;
- a direction bit;
- a mode bit selecting ping-pong or one-shot.

A per-channel counter walks through the current buffer. When a block completes, the channel pulses an interrupt to the CPU. It then either flips to the other buffer or switches itself off. Arming a channel starts it afresh.

Top module: `pdma_ctrl`

## Requirements
- R1: `cpu_req_o[i]` is high exactly when `req_i[i]` is high and `route_dma_i[i]` is 0. A request with `route_dma_i[i]`=0 never causes a bus transfer.
- R2: At most one transfer happens per cycle. Among pending channels, the lowest-numbered channel is served first. The other pending channels are served in later cycles without being lost.
- R3: A DMA-routed request sampled at clock edge k on an active channel, with no contention, appears on the bus (`xfer_o`=1, `xfer_ch_o`=channel) in the cycle that follows edge k+1.
- R4: During a transfer, `ram_addr_o` = selected buffer base + n for byte channels, or + 2·n for word channels, where n is the transfer's index within the block. `per_addr_o` is the channel's peripheral address.
- R5: Direction bit 0 means peripheral to RAM: `ram_we_o`=1 and `per_we_o`=0. Direction bit 1 means RAM to peripheral: `per_we_o`=1 and `ram_we_o`=0.
- R6: Lane rules.
  - Word transfers: both byte-enable bits are 1 and data passes unchanged.
  - Byte, peripheral to RAM: RAM byte enable is 2'b10 at an odd RAM address and 2'b01 at an even one. `ram_wdata_o` repeats the peripheral's low byte in both lanes.
  - Byte, RAM to peripheral: `per_be_o`=2'b01. `per_wdata_o` holds the addressed RAM byte in bits 7:0 (bits 15:8 when the RAM address is odd) and zero in bits 15:8.
- R7: The transfer whose index equals limit−1 is the last of its block. During that transfer, `irq_o[ch]` is high for exactly that one cycle. The next transfer uses index 0.
- R8: With the ping-pong bit set, the buffer alternates A, B, A, … from block to block, and the channel stays active.
- R9: With the ping-pong bit clear, `active_o[ch]` falls after the last transfer of the block. Later requests produce no transfer.
- R10: A request that reaches an inactive channel is dropped, not stored. Arming the channel afterwards produces no transfer until a new request arrives.
- R11: A one-cycle `arm_i[ch]` pulse makes `active_o[ch]` high at the next edge and clears any stored request. It restarts the block at index 0 in buffer A, even in the middle of a block.
- R12: After reset, all channels are inactive. No transfer, write enable, byte enable or interrupt is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Peripheral request lines, one per channel |
| route_dma_i | input | NCH | 1 steers the request to the DMA channel, 0 to the CPU |
| arm_i | input | NCH | One-cycle pulse that starts a channel |
| cfg_word_i | input | NCH | 1 selects word transfers, 0 selects byte transfers |
| cfg_dir_i | input | NCH | 0: peripheral to RAM, 1: RAM to peripheral |
| cfg_pp_i | input | NCH | 1: ping-pong between buffers, 0: one-shot |
| cfg_limit_i | input | NCH*CW | Transfers per block, one CW-bit field per channel |
| cfg_sta_i | input | NCH*AW | Buffer A base per channel |
| cfg_stb_i | input | NCH*AW | Buffer B base per channel |
| cfg_pad_i | input | NCH*PAW | Peripheral address per channel |
| ram_rdata_i | input | DW | RAM port read data |
| per_rdata_i | input | DW | Peripheral read data |
| cpu_req_o | output | NCH | Requests steered to the CPU interrupt logic |
| irq_o | output | NCH | Block-complete interrupt pulses |
| active_o | output | NCH | Channel armed and running |
| xfer_o | output | 1 | A transfer occupies the bus this cycle |
| xfer_ch_o | output | CHW | Channel owning the current transfer |
| ram_addr_o | output | AW | RAM byte address |
| ram_we_o | output | 1 | RAM write enable |
| ram_be_o | output | 2 | RAM byte enables |
| ram_wdata_o | output | DW | RAM write data |
| per_addr_o | output | PAW | Peripheral address |
| per_we_o | output | 1 | Peripheral write enable |
| per_be_o | output | 2 | Peripheral byte enables |
| per_wdata_o | output | DW | Peripheral write data |

## Verification
The assertions check four things on every cycle:
- CPU-steered requests stay clear of DMA-steered lines.
- At most one interrupt fires, and only during the finishing channel's transfer.
- A transfer writes exactly one side and belongs to a channel that was active.
- An arm pulse activates its channel.

Some behaviour can only be shown by the bench's scenarios:
- the address arithmetic across blocks;
- the byte-lane selection;
- the priority order under overlapping requests;
- dropped requests on an idle channel;
- restart after a mid-block re-arm.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic {
    DIR_P2R = 1'b0,
    DIR_R2P = 1'b1
  } dir_e;
endpackage

// File: rtl/pdma_route.sv
module pdma_route #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] route_dma_i,
  output logic [NCH-1:0] cpu_req_o,
  output logic [NCH-1:0] dma_req_o
);
  always_comb begin
    cpu_req_o = req_i & ~route_dma_i;
    dma_req_o = req_i & route_dma_i;
  end
endmodule

// File: rtl/pdma_arb.sv
module pdma_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend_i,
  output logic [NCH-1:0] gnt_o,
  output logic [CHW-1:0] idx_o,
  output logic           valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o   = CHW'(i);
        valid_o = 1'b1;
      end
    end
    gnt_o = valid_o ? (NCH'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan #(
  parameter int CW = 4,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          req_i,
  input  logic          gnt_i,
  input  logic          word_i,
  input  logic          pp_i,
  input  logic [CW-1:0] limit_i,
  input  logic [AW-1:0] sta_i,
  input  logic [AW-1:0] stb_i,
  output logic          pend_o,
  output logic          active_o,
  output logic          irq_o,
  output logic [AW-1:0] ram_addr_o
);
  logic          en_q, en_d;
  logic          pend_q, pend_d;
  logic          buf_q, buf_d;
  logic          irq_q, irq_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last;

  always_comb begin
    last   = (cnt_q + CW'(1)) == limit_i;
    en_d   = en_q;
    buf_d  = buf_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    pend_d = (pend_q & ~gnt_i) | (req_i & en_q);
    if (gnt_i) begin
      if (last) begin
        cnt_d = '0;
        irq_d = 1'b1;
        if (pp_i) buf_d = ~buf_q;
        else      en_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    if (!en_d) pend_d = 1'b0;
    if (arm_i) begin
      en_d   = 1'b1;
      cnt_d  = '0;
      buf_d  = 1'b0;
      pend_d = 1'b0;
    end
    cnt_en = gnt_i | arm_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      buf_q  <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        buf_q <= buf_d;
      end
    end
  end

  always_comb begin
    pend_o     = pend_q;
    active_o   = en_q;
    irq_o      = irq_q;
    ram_addr_o = (buf_q ? stb_i : sta_i) + (AW'(cnt_q) << word_i);
  end
endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int PAW = 8,
  parameter int DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = DW / 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           gnt_valid_i,
  input  logic [CHW-1:0] gnt_ch_i,
  input  logic [AW-1:0]  ram_addr_i,
  input  logic [PAW-1:0] per_addr_i,
  input  logic           word_i,
  input  dir_e           dir_i,
  input  logic [DW-1:0]  ram_rdata_i,
  input  logic [DW-1:0]  per_rdata_i,
  output logic           xfer_o,
  output logic [CHW-1:0] xfer_ch_o,
  output logic [AW-1:0]  ram_addr_o,
  output logic           ram_we_o,
  output logic [1:0]     ram_be_o,
  output logic [DW-1:0]  ram_wdata_o,
  output logic [PAW-1:0] per_addr_o,
  output logic           per_we_o,
  output logic [1:0]     per_be_o,
  output logic [DW-1:0]  per_wdata_o
);
  logic           v_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  raddr_q;
  logic [PAW-1:0] paddr_q;
  logic           word_q;
  dir_e           dir_q;
  logic           hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= 1'b0;
      ch_q    <= '0;
      raddr_q <= '0;
      paddr_q <= '0;
      word_q  <= 1'b0;
      dir_q   <= DIR_P2R;
    end else begin
      v_q <= gnt_valid_i;
      if (gnt_valid_i) begin
        ch_q    <= gnt_ch_i;
        raddr_q <= ram_addr_i;
        paddr_q <= per_addr_i;
        word_q  <= word_i;
        dir_q   <= dir_i;
      end
    end
  end

  always_comb begin
    hi          = raddr_q[0];
    xfer_o      = v_q;
    xfer_ch_o   = ch_q;
    ram_addr_o  = raddr_q;
    per_addr_o  = paddr_q;
    ram_we_o    = v_q && (dir_q == DIR_P2R);
    per_we_o    = v_q && (dir_q == DIR_R2P);
    if (!v_q)        ram_be_o = 2'b00;
    else if (word_q) ram_be_o = 2'b11;
    else             ram_be_o = hi ? 2'b10 : 2'b01;
    if (!v_q)        per_be_o = 2'b00;
    else             per_be_o = word_q ? 2'b11 : 2'b01;
    ram_wdata_o = word_q ? per_rdata_i : {per_rdata_i[BW-1:0], per_rdata_i[BW-1:0]};
    per_wdata_o = word_q ? ram_rdata_i
                         : {{BW{1'b0}}, (hi ? ram_rdata_i[DW-1:BW] : ram_rdata_i[BW-1:0])};
  end
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 4,
  parameter int AW  = 16,
  parameter int PAW = 8,
  parameter int DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic [NCH-1:0]   route_dma_i,
  input  logic [NCH-1:0]   arm_i,
  input  logic [NCH-1:0]   cfg_word_i,
  input  logic [NCH-1:0]   cfg_dir_i,
  input  logic [NCH-1:0]   cfg_pp_i,
  input  logic [NCH*CW-1:0]  cfg_limit_i,
  input  logic [NCH*AW-1:0]  cfg_sta_i,
  input  logic [NCH*AW-1:0]  cfg_stb_i,
  input  logic [NCH*PAW-1:0] cfg_pad_i,
  input  logic [DW-1:0]    ram_rdata_i,
  input  logic [DW-1:0]    per_rdata_i,
  output logic [NCH-1:0]   cpu_req_o,
  output logic [NCH-1:0]   irq_o,
  output logic [NCH-1:0]   active_o,
  output logic             xfer_o,
  output logic [CHW-1:0]   xfer_ch_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic             ram_we_o,
  output logic [1:0]       ram_be_o,
  output logic [DW-1:0]    ram_wdata_o,
  output logic [PAW-1:0]   per_addr_o,
  output logic             per_we_o,
  output logic [1:0]       per_be_o,
  output logic [DW-1:0]    per_wdata_o
);
  logic [NCH-1:0] dma_req, pend, gnt;
  logic [CHW-1:0] gnt_idx;
  logic           gnt_valid;
  logic [AW-1:0]  raddr_a [NCH];
  logic [PAW-1:0] paddr_a [NCH];

  pdma_route #(.NCH(NCH)) u_route (
    .req_i       (req_i),
    .route_dma_i (route_dma_i),
    .cpu_req_o   (cpu_req_o),
    .dma_req_o   (dma_req)
  );

  pdma_arb #(.NCH(NCH)) u_arb (
    .pend_i  (pend),
    .gnt_o   (gnt),
    .idx_o   (gnt_idx),
    .valid_o (gnt_valid)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign paddr_a[c] = cfg_pad_i[c*PAW +: PAW];
    pdma_chan #(.CW(CW), .AW(AW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .arm_i      (arm_i[c]),
      .req_i      (dma_req[c]),
      .gnt_i      (gnt[c]),
      .word_i     (cfg_word_i[c]),
      .pp_i       (cfg_pp_i[c]),
      .limit_i    (cfg_limit_i[c*CW +: CW]),
      .sta_i      (cfg_sta_i[c*AW +: AW]),
      .stb_i      (cfg_stb_i[c*AW +: AW]),
      .pend_o     (pend[c]),
      .active_o   (active_o[c]),
      .irq_o      (irq_o[c]),
      .ram_addr_o (raddr_a[c])
    );
  end

  pdma_xfer #(.NCH(NCH), .AW(AW), .PAW(PAW), .DW(DW)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_valid_i (gnt_valid),
    .gnt_ch_i    (gnt_idx),
    .ram_addr_i  (raddr_a[gnt_idx]),
    .per_addr_i  (paddr_a[gnt_idx]),
    .word_i      (cfg_word_i[gnt_idx]),
    .dir_i       (dir_e'(cfg_dir_i[gnt_idx])),
    .ram_rdata_i (ram_rdata_i),
    .per_rdata_i (per_rdata_i),
    .xfer_o      (xfer_o),
    .xfer_ch_o   (xfer_ch_o),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_be_o    (ram_be_o),
    .ram_wdata_o (ram_wdata_o),
    .per_addr_o  (per_addr_o),
    .per_we_o    (per_we_o),
    .per_be_o    (per_be_o),
    .per_wdata_o (per_wdata_o)
  );
endmodule

// File: rtl/pdma_ctrl_chk.sv
module pdma_ctrl_chk #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] req_i,
  input logic [NCH-1:0] route_dma_i,
  input logic [NCH-1:0] arm_i,
  input logic [NCH-1:0] cpu_req_o,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] active_o,
  input logic           xfer_o,
  input logic [CHW-1:0] xfer_ch_o,
  input logic           ram_we_o,
  input logic           per_we_o,
  input logic [1:0]     ram_be_o
);
  logic [NCH-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= active_o;
  end

  // R1: CPU-steered requests come only from raised lines with DMA steering off
  p_route_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_req_o & ~req_i) == '0) && ((cpu_req_o & route_dma_i) == '0));

  // R7: at most one interrupt per cycle
  p_one_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  // R7: interrupt coincides with the owning channel's transfer
  p_irq_xfer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (xfer_o && irq_o[xfer_ch_o]));

  // R5: a transfer writes exactly one side
  p_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (ram_we_o ^ per_we_o));

  // R12: idle bus drives no writes and no enables
  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_o |-> (!ram_we_o && !per_we_o && ram_be_o == 2'b00));

  // R9: only a channel that was active can own a transfer
  p_src_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> act_q[xfer_ch_o]);

  // R11: an arm pulse activates its channel
  for (genvar i = 0; i < NCH; i++) begin : g_arm
    p_arm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i[i] |=> active_o[i]);
  end
endmodule

bind pdma_ctrl pdma_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .route_dma_i (route_dma_i),
  .arm_i       (arm_i),
  .cpu_req_o   (cpu_req_o),
  .irq_o       (irq_o),
  .active_o    (active_o),
  .xfer_o      (xfer_o),
  .xfer_ch_o   (xfer_ch_o),
  .ram_we_o    (ram_we_o),
  .per_we_o    (per_we_o),
  .ram_be_o    (ram_be_o)
);

// File: tb/pdma_ctrl_test.sv
`timescale 1ns/1ps
module pdma_ctrl_test;
  localparam int NCH = 4, CW = 4, AW = 16, PAW = 8, DW = 16, CHW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req = '0, route = '1, arm = '0, word = '0, dir = '0, pp = '0;
  logic [NCH*CW-1:0]  lim = '0;
  logic [NCH*AW-1:0]  sta = '0, stb = '0;
  logic [NCH*PAW-1:0] pad = '0;
  logic [DW-1:0] ram_rd = 16'hA5C3, per_rd = 16'h5A3C;
  logic [NCH-1:0] cpu_req, irq, active;
  logic xfer, ram_we, per_we;
  logic [CHW-1:0] xch;
  logic [AW-1:0] ram_addr;
  logic [1:0] ram_be, per_be;
  logic [DW-1:0] ram_wd, per_wd;
  logic [PAW-1:0] per_addr;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pdma_ctrl #(.NCH(NCH), .CW(CW), .AW(AW), .PAW(PAW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .route_dma_i(route), .arm_i(arm),
    .cfg_word_i(word), .cfg_dir_i(dir), .cfg_pp_i(pp), .cfg_limit_i(lim),
    .cfg_sta_i(sta), .cfg_stb_i(stb), .cfg_pad_i(pad),
    .ram_rdata_i(ram_rd), .per_rdata_i(per_rd),
    .cpu_req_o(cpu_req), .irq_o(irq), .active_o(active),
    .xfer_o(xfer), .xfer_ch_o(xch), .ram_addr_o(ram_addr), .ram_we_o(ram_we),
    .ram_be_o(ram_be), .ram_wdata_o(ram_wd), .per_addr_o(per_addr),
    .per_we_o(per_we), .per_be_o(per_be), .per_wdata_o(per_wd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic setcfg(input int c, input bit w, input bit d, input bit p, input int l);
    word[c] = w; dir[c] = d; pp[c] = p;
    lim[c*CW +: CW] = CW'(l);
    sta[c*AW +: AW] = AW'(16'h0101 + c * 16'h40);
    stb[c*AW +: AW] = AW'(16'h0800 + c * 16'h40);
    pad[c*PAW +: PAW] = PAW'(8'h10 + c);
  endtask

  task automatic do_arm(input logic [NCH-1:0] m);
    @(negedge clk); arm = m;
    @(negedge clk); arm = '0;
  endtask

  // Pulse request(s), then sample in the cycle after the grant edge (R3)
  task automatic do_req(input int c);
    @(negedge clk); req[c] = 1'b1;
    #1 chk("R1 dma-routed req not seen by cpu", 32'(cpu_req[c]), 0);
    @(negedge clk); req = '0;
    @(negedge clk);
  endtask

  task automatic chk_xfer(input int c, input int idx, input bit bsel, input bit last);
    logic [AW-1:0] base, ea;
    logic hi;
    base = bsel ? stb[c*AW +: AW] : sta[c*AW +: AW];
    ea = base + (AW'(idx) << word[c]);
    hi = ea[0];
    chk("R3 xfer valid", 32'(xfer), 1);
    chk("R3 xfer channel", 32'(xch), c);
    chk("R4/R8 ram address", 32'(ram_addr), 32'(ea));
    chk("R4 peripheral address", 32'(per_addr), 32'(pad[c*PAW +: PAW]));
    chk("R5 ram write", 32'(ram_we), dir[c] ? 0 : 1);
    chk("R5 per write", 32'(per_we), dir[c] ? 1 : 0);
    chk("R7 irq", 32'(irq), last ? (32'd1 << c) : 0);
    if (dir[c] == 1'b0) begin
      chk("R6 ram be", 32'(ram_be), word[c] ? 3 : (hi ? 2 : 1));
      chk("R6 ram wdata", 32'(ram_wd),
          word[c] ? 32'(per_rd) : 32'({per_rd[7:0], per_rd[7:0]}));
    end else begin
      chk("R6 per be", 32'(per_be), word[c] ? 3 : 1);
      chk("R6 per wdata", 32'(per_wd),
          word[c] ? 32'(ram_rd) : 32'(hi ? ram_rd[15:8] : ram_rd[7:0]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset xfer", 32'(xfer), 0);
    chk("R12 reset active", 32'(active), 0);
    chk("R12 reset irq", 32'(irq), 0);
    chk("R12 reset ram_be", 32'(ram_be), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: channel x width x direction x mode, limit = channel + 1
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 2; p++) begin
            int l = c + 1;
            setcfg(c, w[0], d[0], p[0], l);
            do_arm(NCH'(1) << c);
            chk("R11 active after arm", 32'(active[c]), 1);
            for (int k = 0; k < (p ? 3 * l : l); k++) begin
              do_req(c);
              chk_xfer(c, k % l, p ? ((k / l) % 2 == 1) : 1'b0, (k % l) == l - 1);
            end
            if (p) chk("R8 stays active", 32'(active[c]), 1);
            else begin
              chk("R9 inactive after block", 32'(active[c]), 0);
              do_req(c);
              chk("R9 req after one-shot ignored", 32'(xfer), 0);
            end
          end

    // R10: request on an inactive channel is not stored
    setcfg(2, 1'b0, 1'b0, 1'b0, 1);
    do_arm(4'b0100);
    do_req(2);
    chk_xfer(2, 0, 1'b0, 1'b1);
    chk("R10 channel now inactive", 32'(active[2]), 0);
    do_req(2);
    do_arm(4'b0100);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 no stored request", 32'(xfer), 0);
    end
    do_req(2);
    chk_xfer(2, 0, 1'b0, 1'b1);

    // R11: re-arm mid-block restarts at index 0 in buffer A
    setcfg(1, 1'b0, 1'b0, 1'b1, 3);
    do_arm(4'b0010);
    do_req(1); chk_xfer(1, 0, 1'b0, 1'b0);
    do_req(1); chk_xfer(1, 1, 1'b0, 1'b0);
    do_arm(4'b0010);
    do_req(1); chk_xfer(1, 0, 1'b0, 1'b0);

    // R1: CPU-routed request goes to cpu_req_o and causes no transfer
    setcfg(3, 1'b1, 1'b0, 1'b1, 4);
    do_arm(4'b1000);
    route[3] = 1'b0;
    @(negedge clk); req[3] = 1'b1;
    #1 chk("R1 cpu request", 32'(cpu_req), 32'h8);
    @(negedge clk); req = '0;
    #1 chk("R1 cpu request drops", 32'(cpu_req), 0);
    @(negedge clk); chk("R1 no transfer", 32'(xfer), 0);
    @(negedge clk); chk("R1 no transfer later", 32'(xfer), 0);
    route[3] = 1'b1;

    // R2: priority with a late lower-numbered request
    for (int c = 0; c < NCH; c++) setcfg(c, 1'b1, 1'b0, 1'b1, 15);
    do_arm(4'b1111);
    @(negedge clk); req = 4'b0110;
    @(negedge clk); req = 4'b0001;
    @(negedge clk); req = '0;
    chk_xfer(1, 0, 1'b0, 1'b0);
    @(negedge clk); chk_xfer(0, 0, 1'b0, 1'b0);
    @(negedge clk); chk_xfer(2, 0, 1'b0, 1'b0);
    @(negedge clk); chk("R2 bus idle after queue", 32'(xfer), 0);
    // R2: all four at once are served in index order, back to back
    @(negedge clk); req = 4'b1111;
    @(negedge clk); req = '0;
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      chk_xfer(c, (c == 3) ? 0 : 1, 1'b0, 1'b0);
    end
    @(negedge clk); chk("R2 one per cycle then idle", 32'(xfer), 0);

    finish_run();
  end
endmodule